// File: doc/BRIEF.md
# Fast-Window Port Mirror

This block gives a processor a small, fast address window in which up to four slots each mirror one physical I/O port. A mapping register per slot chooses the port it mirrors, and the mapping can change at run time. Each slot exposes only four of the port's registers: direction, output, input level and interrupt flags. The remaining port registers stay reachable only through the normal port address path, which is outside this block.

Reads through a slot return the live contents of the mapped port's register in the same cycle. Writes through a slot are turned into one registered update command toward the port register file, which is the single store shared with the normal address path. As a result, both views always agree. Inside the low part of the window a write can also set or clear a single bit without a read-modify-write. Each update reaches the port's register, and so its pins, two clock edges after the access.

Top module: `vport_map`

## Requirements
- R1: After reset every slot maps to port 0, the mapping registers (addresses 32..35) read 0, and no update command is pending (fwd_vld_o low).
- R2: Slot k occupies window addresses 4k..4k+3, at offsets direction 0, output 1, input 2 and flags 3. A read (fw_req_i high, fw_we_i low) of a slot address returns that register of the mapped port in the same cycle. Unused addresses (16..31, 36..63) read 0.
- R3: A full write (fw_kind_i = 0) of value p to address 32+k makes slot k mirror port p from the next cycle on. The same address reads back p.
- R4: A full write to a slot's direction or output offset issues an update with fwd_op_o = 0 (load), fwd_reg_o = offset (0 or 1), fwd_port_o = the mapped port and fwd_data_o = the written data.
- R5: A single-bit write uses fw_kind_i = 1 to set or 2 to clear the bit numbered by fw_bit_i. On a direction or output offset it issues fwd_op_o = 1 (OR) or 2 (AND-NOT) with a one-hot mask, and fw_wdata_i is ignored. Only the addressed bit of the port register changes.
- R6: fwd_vld_o is high for exactly the cycle after the accepted write. A port register that applies the command at its next edge shows the change two edges after the access.
- R7: Writes of any kind to a slot's input offset are ignored: no update is issued and the input value is unchanged.
- R8: On the flags offset, a full write issues fwd_op_o = 2 with the written data as the mask, so each 1 clears a flag. A single-bit set clears that one flag. A single-bit clear does nothing.
- R9: A single-bit write at an address of 32 or above is ignored, including on the mapping registers.
- R10: Slot reads and writes at the port's normal address reach the same storage. A change at the normal address is visible through every slot mapped to that port, and two slots mapped to one port read the same values.
- R11: Writes to unused addresses, and writes with the reserved kind 3, change nothing and issue no update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fw_req_i | input | 1 | Window access request |
| fw_we_i | input | 1 | 1 = write, 0 = read |
| fw_kind_i | input | 2 | Write kind: 0 full, 1 bit set, 2 bit clear, 3 reserved |
| fw_addr_i | input | AW (6) | Window address |
| fw_bit_i | input | 3 | Bit number for single-bit writes |
| fw_wdata_i | input | W (8) | Write data |
| fw_rdata_o | output | W (8) | Read data, valid in the request cycle |
| pdir_i | input | NP*W (64) | Direction registers of all ports, port p at bits p*W |
| pout_i | input | NP*W (64) | Output registers of all ports |
| pin_i | input | NP*W (64) | Input levels of all ports |
| pflag_i | input | NP*W (64) | Interrupt flag registers of all ports |
| fwd_vld_o | output | 1 | Update command valid |
| fwd_port_o | output | 3 | Target physical port |
| fwd_reg_o | output | 2 | Target register: 0 dir, 1 out, 2 in, 3 flags |
| fwd_op_o | output | 2 | 0 load, 1 OR with mask, 2 AND-NOT with mask |
| fwd_data_o | output | W (8) | Load value or mask |

## Verification
Reads are combinational, so the bench samples fw_rdata_o one time step after it drives the address, still inside the request cycle. Mapping writes take effect at the first edge, so the next read already uses the new port. An update command is checked on the falling edge right after the access edge, and at that point the port register stub must still hold its old value. The stub is then checked one cycle later, after the second edge, for the new value. Ignored accesses are checked at the same two points: no command, and an unchanged register or read value.

// File: rtl/vpm_pkg.sv
`timescale 1ns/1ps
package vpm_pkg;
  typedef enum logic [1:0] {REG_DIR = 2'd0, REG_OUT = 2'd1, REG_IN = 2'd2, REG_FLAG = 2'd3} vpm_reg_e;
  typedef enum logic [1:0] {KIND_FULL = 2'd0, KIND_BSET = 2'd1, KIND_BCLR = 2'd2, KIND_RSVD = 2'd3} vpm_kind_e;
  typedef enum logic [1:0] {OP_LOAD = 2'd0, OP_OR = 2'd1, OP_ANDN = 2'd2, OP_NONE = 2'd3} vpm_op_e;
endpackage

// File: rtl/vpm_decode.sv
`timescale 1ns/1ps
module vpm_decode
  import vpm_pkg::*;
#(
  parameter int AW        = 6,
  parameter int NS        = 4,
  parameter int SW        = 2,
  parameter int SLOT_BASE = 0,
  parameter int MAP_BASE  = 32,
  parameter int BIT_LIMIT = 32
) (
  input  logic [AW-1:0] addr_i,
  output logic          slot_hit_o,
  output logic [SW-1:0] slot_idx_o,
  output vpm_reg_e      reg_o,
  output logic          map_hit_o,
  output logic [SW-1:0] map_idx_o,
  output logic          bitop_ok_o
);
  localparam logic [AW:0] SLOT_LO = (AW+1)'(SLOT_BASE);
  localparam logic [AW:0] SLOT_HI = (AW+1)'(SLOT_BASE + 4*NS);
  localparam logic [AW:0] MAP_LO  = (AW+1)'(MAP_BASE);
  localparam logic [AW:0] MAP_HI  = (AW+1)'(MAP_BASE + NS);
  localparam logic [AW:0] BIT_HI  = (AW+1)'(BIT_LIMIT);

  logic [AW:0]   addr_x;
  logic [AW-1:0] s_off, m_off;

  assign addr_x     = {1'b0, addr_i};
  assign s_off      = addr_i - AW'(SLOT_BASE);
  assign m_off      = addr_i - AW'(MAP_BASE);
  assign slot_hit_o = (addr_x >= SLOT_LO) && (addr_x < SLOT_HI);
  assign slot_idx_o = SW'(s_off >> 2);
  assign reg_o      = vpm_reg_e'(s_off[1:0]);
  assign map_hit_o  = (addr_x >= MAP_LO) && (addr_x < MAP_HI);
  assign map_idx_o  = SW'(m_off);
  assign bitop_ok_o = addr_x < BIT_HI;
endmodule

// File: rtl/vpm_map_regs.sv
`timescale 1ns/1ps
module vpm_map_regs #(
  parameter int NS = 4,
  parameter int PW = 3,
  parameter int SW = 2
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [SW-1:0]          idx_i,
  input  logic [PW-1:0]          port_i,
  output logic [NS-1:0][PW-1:0]  map_o
);
  for (genvar k = 0; k < NS; k++) begin : g_slot
    logic [PW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && (idx_i == SW'(k)))   q <= port_i;
    end
    assign map_o[k] = q;
  end
endmodule

// File: rtl/vpm_rdmux.sv
`timescale 1ns/1ps
module vpm_rdmux
  import vpm_pkg::*;
#(
  parameter int NS = 4,
  parameter int NP = 8,
  parameter int PW = 3,
  parameter int SW = 2,
  parameter int W  = 8
) (
  input  logic                  rd_en_i,
  input  logic                  slot_hit_i,
  input  vpm_reg_e              reg_i,
  input  logic [PW-1:0]         port_i,
  input  logic                  map_hit_i,
  input  logic [SW-1:0]         map_idx_i,
  input  logic [NS-1:0][PW-1:0] map_i,
  input  logic [NP*W-1:0]       pdir_i,
  input  logic [NP*W-1:0]       pout_i,
  input  logic [NP*W-1:0]       pin_i,
  input  logic [NP*W-1:0]       pflag_i,
  output logic [W-1:0]          rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (slot_hit_i) begin
        unique case (reg_i)
          REG_DIR:  rdata_o = pdir_i[port_i*W +: W];
          REG_OUT:  rdata_o = pout_i[port_i*W +: W];
          REG_IN:   rdata_o = pin_i[port_i*W +: W];
          REG_FLAG: rdata_o = pflag_i[port_i*W +: W];
          default:  rdata_o = '0;
        endcase
      end else if (map_hit_i) begin
        rdata_o = W'(map_i[map_idx_i]);
      end
    end
  end
endmodule

// File: rtl/vpm_fwd.sv
`timescale 1ns/1ps
module vpm_fwd
  import vpm_pkg::*;
#(
  parameter int W  = 8,
  parameter int PW = 3,
  parameter int BW = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_en_i,
  input  logic          slot_hit_i,
  input  vpm_reg_e      reg_i,
  input  vpm_kind_e     kind_i,
  input  logic [BW-1:0] bit_i,
  input  logic          bitop_ok_i,
  input  logic [PW-1:0] port_i,
  input  logic [W-1:0]  wdata_i,
  output logic          vld_o,
  output logic [PW-1:0] port_o,
  output logic [1:0]    reg_o,
  output logic [1:0]    op_o,
  output logic [W-1:0]  data_o
);
  logic [W-1:0] mask, data_n;
  vpm_op_e      op_n;

  assign mask = W'(1) << bit_i;

  always_comb begin
    op_n   = OP_NONE;
    data_n = wdata_i;
    if (wr_en_i && slot_hit_i) begin
      unique case (reg_i)
        REG_DIR, REG_OUT: begin
          unique case (kind_i)
            KIND_FULL: op_n = OP_LOAD;
            KIND_BSET: if (bitop_ok_i) begin op_n = OP_OR;   data_n = mask; end
            KIND_BCLR: if (bitop_ok_i) begin op_n = OP_ANDN; data_n = mask; end
            default:   op_n = OP_NONE;
          endcase
        end
        REG_FLAG: begin
          // flags are write-one-to-clear; a bit clear writes a 0 and is a no-op
          unique case (kind_i)
            KIND_FULL: op_n = OP_ANDN;
            KIND_BSET: if (bitop_ok_i) begin op_n = OP_ANDN; data_n = mask; end
            default:   op_n = OP_NONE;
          endcase
        end
        default: op_n = OP_NONE;
      endcase
    end
  end

  logic          vld_q;
  logic [PW-1:0] port_q;
  vpm_reg_e      reg_q;
  vpm_op_e       op_q;
  logic [W-1:0]  data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q  <= 1'b0;
      port_q <= '0;
      reg_q  <= REG_DIR;
      op_q   <= OP_NONE;
      data_q <= '0;
    end else begin
      vld_q <= (op_n != OP_NONE);
      if (op_n != OP_NONE) begin
        port_q <= port_i;
        reg_q  <= reg_i;
        op_q   <= op_n;
        data_q <= data_n;
      end
    end
  end

  assign vld_o  = vld_q;
  assign port_o = port_q;
  assign reg_o  = reg_q;
  assign op_o   = op_q;
  assign data_o = data_q;
endmodule

// File: rtl/vport_map.sv
`timescale 1ns/1ps
module vport_map
  import vpm_pkg::*;
#(
  parameter int NP        = 8,
  parameter int NS        = 4,
  parameter int W         = 8,
  parameter int AW        = 6,
  parameter int SLOT_BASE = 0,
  parameter int MAP_BASE  = 32,
  parameter int BIT_LIMIT = 32,
  localparam int PW = (NP > 1) ? $clog2(NP) : 1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            fw_req_i,
  input  logic            fw_we_i,
  input  logic [1:0]      fw_kind_i,
  input  logic [AW-1:0]   fw_addr_i,
  input  logic [BW-1:0]   fw_bit_i,
  input  logic [W-1:0]    fw_wdata_i,
  output logic [W-1:0]    fw_rdata_o,
  input  logic [NP*W-1:0] pdir_i,
  input  logic [NP*W-1:0] pout_i,
  input  logic [NP*W-1:0] pin_i,
  input  logic [NP*W-1:0] pflag_i,
  output logic            fwd_vld_o,
  output logic [PW-1:0]   fwd_port_o,
  output logic [1:0]      fwd_reg_o,
  output logic [1:0]      fwd_op_o,
  output logic [W-1:0]    fwd_data_o
);
  logic                  slot_hit, map_hit, bitop_ok, map_we, wr_en, rd_en;
  logic [SW-1:0]         slot_idx, map_idx;
  vpm_reg_e              reg_sel;
  vpm_kind_e             kind;
  logic [NS-1:0][PW-1:0] map_q;
  logic [PW-1:0]         slot_port;

  assign kind      = vpm_kind_e'(fw_kind_i);
  assign wr_en     = fw_req_i & fw_we_i;
  assign rd_en     = fw_req_i & ~fw_we_i;
  assign map_we    = wr_en & map_hit & (kind == KIND_FULL);
  assign slot_port = map_q[slot_idx];

  vpm_decode #(
    .AW(AW), .NS(NS), .SW(SW),
    .SLOT_BASE(SLOT_BASE), .MAP_BASE(MAP_BASE), .BIT_LIMIT(BIT_LIMIT)
  ) i_decode (
    .addr_i     (fw_addr_i),
    .slot_hit_o (slot_hit),
    .slot_idx_o (slot_idx),
    .reg_o      (reg_sel),
    .map_hit_o  (map_hit),
    .map_idx_o  (map_idx),
    .bitop_ok_o (bitop_ok)
  );

  vpm_map_regs #(.NS(NS), .PW(PW), .SW(SW)) i_map_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (map_we),
    .idx_i  (map_idx),
    .port_i (PW'(fw_wdata_i)),
    .map_o  (map_q)
  );

  vpm_rdmux #(.NS(NS), .NP(NP), .PW(PW), .SW(SW), .W(W)) i_rdmux (
    .rd_en_i    (rd_en),
    .slot_hit_i (slot_hit),
    .reg_i      (reg_sel),
    .port_i     (slot_port),
    .map_hit_i  (map_hit),
    .map_idx_i  (map_idx),
    .map_i      (map_q),
    .pdir_i     (pdir_i),
    .pout_i     (pout_i),
    .pin_i      (pin_i),
    .pflag_i    (pflag_i),
    .rdata_o    (fw_rdata_o)
  );

  vpm_fwd #(.W(W), .PW(PW), .BW(BW)) i_fwd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_en_i    (wr_en),
    .slot_hit_i (slot_hit),
    .reg_i      (reg_sel),
    .kind_i     (kind),
    .bit_i      (fw_bit_i),
    .bitop_ok_i (bitop_ok),
    .port_i     (slot_port),
    .wdata_i    (fw_wdata_i),
    .vld_o      (fwd_vld_o),
    .port_o     (fwd_port_o),
    .reg_o      (fwd_reg_o),
    .op_o       (fwd_op_o),
    .data_o     (fwd_data_o)
  );
endmodule

// File: rtl/vport_map_chk.sv
`timescale 1ns/1ps
module vport_map_chk #(
  parameter int W         = 8,
  parameter int AW        = 6,
  parameter int NS        = 4,
  parameter int SLOT_BASE = 0,
  parameter int BIT_LIMIT = 32
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          fw_req_i,
  input logic          fw_we_i,
  input logic [1:0]    fw_kind_i,
  input logic [AW-1:0] fw_addr_i,
  input logic          fwd_vld_o,
  input logic [1:0]    fwd_reg_o,
  input logic [1:0]    fwd_op_o,
  input logic [W-1:0]  fwd_data_o
);
  logic [AW:0]   ax;
  logic [AW-1:0] off;
  logic          wr, in_slots, high_bitop, flag_bclr;

  assign ax         = {1'b0, fw_addr_i};
  assign off        = fw_addr_i - AW'(SLOT_BASE);
  assign wr         = fw_req_i && fw_we_i;
  assign in_slots   = (ax >= (AW+1)'(SLOT_BASE)) && (ax < (AW+1)'(SLOT_BASE + 4*NS));
  assign high_bitop = wr && (fw_kind_i != 2'd0) && (ax >= (AW+1)'(BIT_LIMIT));
  assign flag_bclr  = wr && (fw_kind_i == 2'd2) && in_slots && (off[1:0] == 2'd3);

  a_r6_cmd_follows_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_vld_o |-> $past(wr));

  a_r7_input_never_target: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fwd_vld_o |-> (fwd_reg_o != 2'd2));

  a_r5_bit_mask_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_vld_o && $past(fw_kind_i != 2'd0)) |-> ($countones(fwd_data_o) == 1));

  a_r9_high_bitop_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    high_bitop |=> !fwd_vld_o);

  a_r8_flag_bclr_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_bclr |=> !fwd_vld_o);

  a_r8_flag_only_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fwd_vld_o && (fwd_reg_o == 2'd3)) |-> (fwd_op_o == 2'd2));
endmodule

bind vport_map vport_map_chk #(
  .W(W), .AW(AW), .NS(NS), .SLOT_BASE(SLOT_BASE), .BIT_LIMIT(BIT_LIMIT)
) i_vport_map_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .fw_req_i   (fw_req_i),
  .fw_we_i    (fw_we_i),
  .fw_kind_i  (fw_kind_i),
  .fw_addr_i  (fw_addr_i),
  .fwd_vld_o  (fwd_vld_o),
  .fwd_reg_o  (fwd_reg_o),
  .fwd_op_o   (fwd_op_o),
  .fwd_data_o (fwd_data_o)
);

// File: tb/test_vport_map.sv
`timescale 1ns/1ps
module test_vport_map;
  localparam int NP = 8;
  localparam int W  = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            fw_req = 1'b0, fw_we = 1'b0;
  logic [1:0]      fw_kind = '0;
  logic [5:0]      fw_addr = '0;
  logic [2:0]      fw_bit = '0;
  logic [W-1:0]    fw_wdata = '0;
  logic [W-1:0]    fw_rdata;
  logic [NP*W-1:0] pdir, pout, pin, pflag;
  logic            fwd_vld;
  logic [2:0]      fwd_port;
  logic [1:0]      fwd_reg, fwd_op;
  logic [W-1:0]    fwd_data;

  logic            nrm_vld = 1'b0;
  logic [2:0]      nrm_port = '0;
  logic [1:0]      nrm_reg = '0;
  logic [W-1:0]    nrm_data = '0;
  logic [W-1:0]    s_dir [NP];
  logic [W-1:0]    s_out [NP];
  logic [W-1:0]    s_in  [NP];
  logic [W-1:0]    s_flag[NP];

  int checks = 0;
  int errors = 0;

  always #2.5 clk_i = ~clk_i;

  vport_map i_vport_map (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .fw_req_i(fw_req), .fw_we_i(fw_we), .fw_kind_i(fw_kind), .fw_addr_i(fw_addr),
    .fw_bit_i(fw_bit), .fw_wdata_i(fw_wdata), .fw_rdata_o(fw_rdata),
    .pdir_i(pdir), .pout_i(pout), .pin_i(pin), .pflag_i(pflag),
    .fwd_vld_o(fwd_vld), .fwd_port_o(fwd_port), .fwd_reg_o(fwd_reg),
    .fwd_op_o(fwd_op), .fwd_data_o(fwd_data)
  );

  // port register stub: one store, written by update commands and by the normal address path
  function automatic logic [W-1:0] apply(input logic [W-1:0] v, input logic [1:0] op, input logic [W-1:0] d);
    case (op)
      2'd0:    return d;
      2'd1:    return v | d;
      2'd2:    return v & ~d;
      default: return v;
    endcase
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NP; p++) begin
        s_dir[p] <= '0; s_out[p] <= '0; s_in[p] <= '0; s_flag[p] <= '0;
      end
    end else begin
      if (fwd_vld) begin
        case (fwd_reg)
          2'd0: s_dir[fwd_port]  <= apply(s_dir[fwd_port],  fwd_op, fwd_data);
          2'd1: s_out[fwd_port]  <= apply(s_out[fwd_port],  fwd_op, fwd_data);
          2'd2: s_in[fwd_port]   <= apply(s_in[fwd_port],   fwd_op, fwd_data);
          default: s_flag[fwd_port] <= apply(s_flag[fwd_port], fwd_op, fwd_data);
        endcase
      end
      if (nrm_vld) begin
        case (nrm_reg)
          2'd0: s_dir[nrm_port]  <= nrm_data;
          2'd1: s_out[nrm_port]  <= nrm_data;
          2'd2: s_in[nrm_port]   <= nrm_data;
          default: s_flag[nrm_port] <= nrm_data;
        endcase
      end
    end
  end

  always_comb begin
    for (int p = 0; p < NP; p++) begin
      pdir[p*W +: W]  = s_dir[p];
      pout[p*W +: W]  = s_out[p];
      pin[p*W +: W]   = s_in[p];
      pflag[p*W +: W] = s_flag[p];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic fw_write(input logic [5:0] a, input logic [1:0] k, input logic [2:0] b, input logic [W-1:0] d);
    @(negedge clk_i);
    fw_req = 1'b1; fw_we = 1'b1; fw_addr = a; fw_kind = k; fw_bit = b; fw_wdata = d;
    @(negedge clk_i);
    fw_req = 1'b0; fw_we = 1'b0;
  endtask

  task automatic fw_read(input logic [5:0] a, output logic [W-1:0] v);
    @(negedge clk_i);
    fw_req = 1'b1; fw_we = 1'b0; fw_addr = a;
    #1 v = fw_rdata;
    fw_req = 1'b0;
  endtask

  task automatic nrm_write(input logic [2:0] p, input logic [1:0] r, input logic [W-1:0] d);
    @(negedge clk_i);
    nrm_vld = 1'b1; nrm_port = p; nrm_reg = r; nrm_data = d;
    @(negedge clk_i);
    nrm_vld = 1'b0;
  endtask

  task automatic chk_cmd(input string tag, input logic [2:0] p, input logic [1:0] r,
                         input logic [1:0] op, input logic [W-1:0] d);
    chk({tag, " vld"},  32'(fwd_vld),  32'd1);
    chk({tag, " port"}, 32'(fwd_port), 32'(p));
    chk({tag, " reg"},  32'(fwd_reg),  32'(r));
    chk({tag, " op"},   32'(fwd_op),   32'(op));
    chk({tag, " data"}, 32'(fwd_data), 32'(d));
  endtask

  task automatic t_reset();
    logic [W-1:0] v;
    chk("R1 no pending command", 32'(fwd_vld), 32'd0);
    for (int k = 0; k < 4; k++) begin
      fw_read(6'(32 + k), v);
      chk("R1 map register zero", 32'(v), 32'd0);
    end
  endtask

  task automatic t_map();
    logic [W-1:0] v;
    nrm_write(3'd0, 2'd0, 8'hA1);
    nrm_write(3'd5, 2'd1, 8'h5C);
    nrm_write(3'd5, 2'd2, 8'h3E);
    nrm_write(3'd5, 2'd3, 8'h81);
    nrm_write(3'd2, 2'd0, 8'h44);
    fw_read(6'd0, v);  chk("R2 slot0 dir of port0", 32'(v), 32'hA1);
    fw_write(6'd33, 2'd0, 3'd0, 8'h05);
    fw_read(6'd33, v); chk("R3 map1 readback", 32'(v), 32'h05);
    fw_read(6'd5, v);  chk("R2 slot1 out", 32'(v), 32'h5C);
    fw_read(6'd6, v);  chk("R2 slot1 in", 32'(v), 32'h3E);
    fw_read(6'd7, v);  chk("R2 slot1 flags", 32'(v), 32'h81);
    fw_write(6'd35, 2'd0, 3'd0, 8'h05);
    fw_read(6'd13, v); chk("R10 slot3 aliases port5", 32'(v), 32'h5C);
    fw_write(6'd32, 2'd0, 3'd0, 8'h02);
    fw_read(6'd0, v);  chk("R3 slot0 remapped to port2", 32'(v), 32'h44);
    fw_read(6'd20, v); chk("R2 unused address reads zero", 32'(v), 32'h00);
    nrm_write(3'd5, 2'd1, 8'h11);
    fw_read(6'd5, v);  chk("R10 normal write seen in slot1", 32'(v), 32'h11);
    fw_read(6'd13, v); chk("R10 normal write seen in slot3", 32'(v), 32'h11);
  endtask

  task automatic t_full_write();
    logic [W-1:0] v;
    fw_write(6'd4, 2'd0, 3'd0, 8'hF0);
    chk_cmd("R4 full dir write", 3'd5, 2'd0, 2'd0, 8'hF0);
    chk("R6 port unchanged after one edge", 32'(s_dir[5]), 32'h00);
    @(negedge clk_i);
    chk("R6 port updated after two edges", 32'(s_dir[5]), 32'hF0);
    chk("R6 command lasts one cycle", 32'(fwd_vld), 32'd0);
    fw_read(6'd4, v);  chk("R4 readback through slot1", 32'(v), 32'hF0);
    fw_read(6'd12, v); chk("R10 readback through slot3", 32'(v), 32'hF0);
  endtask

  task automatic t_bit_ops();
    fw_write(6'd5, 2'd1, 3'd6, 8'h00);
    chk_cmd("R5 bit set", 3'd5, 2'd1, 2'd1, 8'h40);
    @(negedge clk_i);
    chk("R5 out after bit set", 32'(s_out[5]), 32'h51);
    fw_write(6'd13, 2'd2, 3'd0, 8'hFF);
    chk_cmd("R5 bit clear", 3'd5, 2'd1, 2'd2, 8'h01);
    chk("R6 bit clear not yet visible", 32'(s_out[5]), 32'h51);
    @(negedge clk_i);
    chk("R5 out after bit clear", 32'(s_out[5]), 32'h50);
  endtask

  task automatic t_input_ignored();
    logic [W-1:0] v;
    fw_write(6'd6, 2'd0, 3'd0, 8'h00);
    chk("R7 full input write no command", 32'(fwd_vld), 32'd0);
    fw_write(6'd6, 2'd1, 3'd1, 8'h00);
    chk("R7 bit input write no command", 32'(fwd_vld), 32'd0);
    @(negedge clk_i);
    chk("R7 input value kept", 32'(s_in[5]), 32'h3E);
    fw_read(6'd6, v); chk("R7 input reads back", 32'(v), 32'h3E);
  endtask

  task automatic t_flags();
    fw_write(6'd7, 2'd0, 3'd0, 8'h01);
    chk_cmd("R8 flag full write clears", 3'd5, 2'd3, 2'd2, 8'h01);
    @(negedge clk_i);
    chk("R8 flags after full write", 32'(s_flag[5]), 32'h80);
    nrm_write(3'd5, 2'd3, 8'h81);
    fw_write(6'd7, 2'd1, 3'd7, 8'h00);
    chk_cmd("R8 flag bit set clears", 3'd5, 2'd3, 2'd2, 8'h80);
    @(negedge clk_i);
    chk("R8 flags after bit set", 32'(s_flag[5]), 32'h01);
    fw_write(6'd7, 2'd2, 3'd0, 8'h00);
    chk("R8 flag bit clear no command", 32'(fwd_vld), 32'd0);
    @(negedge clk_i);
    chk("R8 flags unchanged by bit clear", 32'(s_flag[5]), 32'h01);
  endtask

  task automatic t_ignored();
    logic [W-1:0] v;
    fw_write(6'd33, 2'd1, 3'd2, 8'h00);
    chk("R9 high bit set no command", 32'(fwd_vld), 32'd0);
    fw_read(6'd33, v); chk("R9 map1 kept after bit set", 32'(v), 32'h05);
    fw_write(6'd33, 2'd2, 3'd0, 8'h00);
    fw_read(6'd33, v); chk("R9 map1 kept after bit clear", 32'(v), 32'h05);
    fw_write(6'd40, 2'd0, 3'd0, 8'hFF);
    chk("R11 unused write no command", 32'(fwd_vld), 32'd0);
    fw_read(6'd40, v); chk("R11 unused still zero", 32'(v), 32'h00);
    fw_write(6'd5, 2'd3, 3'd0, 8'hFF);
    chk("R11 reserved kind no command", 32'(fwd_vld), 32'd0);
    @(negedge clk_i);
    chk("R11 out unchanged by reserved kind", 32'(s_out[5]), 32'h50);
  endtask

  bit done = 1'b0;

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_map();
    t_full_write();
    t_bit_ops();
    t_input_ignored();
    t_flags();
    t_ignored();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule